// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer with Wait Signalling

This block drives the read side of a synchronous burst memory array. When a burst is started, it captures a start word address and a set of configuration fields. It then waits a programmable first-access latency and emits a stream of array word addresses. An output-valid strobe marks each cycle that carries a word on the 16-bit data bus. A wait signal tells the host which cycles carry no data. The array is a behavioural word store whose contents are a fixed function of the address.

The supported modes are:
- finite bursts of 4, 8 or 16 words, or a continuous burst;
- wrapping or non-wrapping address progression;
- linear or interleaved word order.

When a non-wrapping or continuous burst starts at an address that is not a multiple of 4 and then first enters a new 16-word row, it pauses. The length of this pause grows with the start offset. The wait signal marks the pause. Its polarity can be selected, and it can either coincide with the empty cycles or lead them by one clock. Releasing the burst request or the chip enable ends the burst at the next clock.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is asserted and until a burst starts, `dvalid` is 0, `dout` is 0 and `wait_o` sits at its deasserted level.
- R2: The first word is valid on the cycle that follows the L-th clock edge after the edge that samples the start. L is `cfg_lat`; values below 2 act as 2. In coincident timing, `wait_o` is asserted for all L cycles of the latency.
- R3: In wrap mode (`cfg_nowrap`=0) with linear order (`cfg_ilv`=0), a burst of N words emits `base + ((s mod N) + k) mod N` for k = 0 to N-1. Here s is the start address and base is s rounded down to a multiple of N. N is 4, 8 or 16 for `cfg_len` values 0, 1 or 2.
- R4: In wrap mode with interleaved order (`cfg_ilv`=1), word k is `base + ((s mod N) XOR k)`.
- R5: In no-wrap mode (`cfg_nowrap`=1), word k is `s + k` modulo 2^AW for N words, and `cfg_ilv` has no effect.
- R6: With `cfg_len`=3 the burst is continuous. Word k is `s + k` with no end, whatever the values of `cfg_nowrap` and `cfg_ilv`.
- R7: In no-wrap or continuous mode, let off be s mod 4 and D = max(0, L + off - 4). If off is not 0, a gap of D cycles with `dvalid`=0 is placed before the first word whose address is a multiple of 16. No gap is placed when off is 0, and no gap is placed at any later row crossing.
- R8: With `cfg_wait_early`=1, `wait_o` is asserted in each burst cycle whose next cycle is a latency or gap cycle. It leads those cycles by one clock and is never asserted outside a running burst.
- R9: `cfg_wait_hi`=1 makes `wait_o` active high. With 0 it is active low. The deasserted level is always the complement of the asserted level.
- R10: With `cfg_hold2`=1 each word stays valid, at the same address, for two consecutive cycles. With 0 it stays valid for one cycle.
- R11: If `burst_go` or `chip_en` is low at a clock edge, the next cycle has `dvalid`=0 and `wait_o` deasserted.
- R12: While `dvalid` is 1, `dout` = {`arr_addr`[7:0] XOR 8'hC3, `arr_addr`[7:0]}. Otherwise it is 0.
- R13: After the last word of a finite burst, `dvalid` stays 0 and `wait_o` stays deasserted while `burst_go` remains high. A new burst needs `burst_go` to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip enable; low ends any burst |
| burst_go | input | 1 | Burst request; high starts a burst from idle and keeps it running |
| start_addr | input | AW | Start word address, sampled at burst start |
| cfg_len | input | 2 | Burst length: 0=4, 1=8, 2=16, 3=continuous |
| cfg_nowrap | input | 1 | 1 = linear advance past the burst-length boundary |
| cfg_ilv | input | 1 | 1 = interleaved order in wrap mode |
| cfg_wait_early | input | 1 | 1 = wait leads empty cycles by one clock |
| cfg_wait_hi | input | 1 | Wait polarity: 1 = active high |
| cfg_hold2 | input | 1 | 1 = each word held for two clocks |
| cfg_lat | input | 3 | First-access latency in clocks (2 to 7) |
| arr_addr | output | AW | Current array word address |
| dout | output | 16 | Data word from the array |
| dvalid | output | 1 | Data bus holds a valid word |
| wait_o | output | 1 | Wait signal |

## Verification
Counting from the edge that samples the start, the latency cycles are cycles 0 to L-1. The first word is valid in cycle L. Each word occupies one or two cycles, and any gap of D cycles comes immediately before the word at the row boundary. In coincident timing, `wait_o` in cycle c reflects whether cycle c is empty. In early timing it reflects cycle c+1. The bench builds this per-cycle schedule from the configuration. It drives the request on a falling edge and compares every output on each later falling edge, so that cycle c is read exactly c+1 rising edges after the request was driven. The effect of an abort is checked one falling edge after the request is dropped.

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en,
  input  logic          burst_go,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_nowrap,
  input  logic          cfg_ilv,
  input  logic          cfg_wait_early,
  input  logic          cfg_wait_hi,
  input  logic          cfg_hold2,
  input  logic [2:0]    cfg_lat,
  output logic [AW-1:0] arr_addr,
  output logic [15:0]   dout,
  output logic          dvalid,
  output logic          wait_o
);

  typedef enum logic [2:0] {S_IDLE, S_LAT, S_DATA, S_STALL, S_DONE} st_t;

  st_t           st, st_n;
  logic [3:0]    cnt, cnt_n;
  logic          hold_c, hold_n;
  logic          stalled, stalled_n;
  logic [AW-1:0] k, k_n;

  logic [AW-1:0] s_q;
  logic [1:0]    len_q;
  logic          nowrap_q, ilv_q, early_q, hold2_q;
  logic [2:0]    lat_q;

  wire           run    = burst_go && chip_en;
  wire [2:0]     lat_in = (cfg_lat < 3'd2) ? 3'd2 : cfg_lat;
  wire           cont   = (len_q == 2'd3);
  wire           lin    = nowrap_q || cont;
  wire [AW-1:0]  msk    = (AW'(4) << len_q) - AW'(1);
  wire [AW-1:0]  kn1    = k + AW'(1);
  wire [AW-1:0]  nxt_a  = s_q + kn1;
  wire [3:0]     lsum   = {1'b0, lat_q} + {2'b00, s_q[1:0]};
  wire [3:0]     gap    = (lsum > 4'd4) ? lsum - 4'd4 : 4'd0;
  wire           word_done = !hold2_q || hold_c;
  wire           row_cross = lin && !stalled && (s_q[1:0] != 2'd0) &&
                             (gap != 4'd0) && (nxt_a[3:0] == 4'd0);

  wire [AW-1:0]  a_lin  = s_q + k;
  wire [AW-1:0]  a_wrap = (s_q & ~msk) | (a_lin & msk);
  wire [AW-1:0]  a_ilv  = (s_q & ~msk) | ((s_q ^ k) & msk);

  assign arr_addr = lin ? a_lin : (ilv_q ? a_ilv : a_wrap);

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    hold_n    = hold_c;
    stalled_n = stalled;
    k_n       = k;
    case (st)
      S_IDLE: if (run) begin
        st_n      = S_LAT;
        cnt_n     = {1'b0, lat_in};
        stalled_n = 1'b0;
      end
      S_LAT: if (cnt == 4'd1) begin
        st_n   = S_DATA;
        k_n    = '0;
        hold_n = 1'b0;
      end else cnt_n = cnt - 4'd1;
      S_DATA: if (!word_done) hold_n = 1'b1;
      else if (!cont && k == msk) st_n = S_DONE;
      else begin
        k_n    = kn1;
        hold_n = 1'b0;
        if (row_cross) begin
          st_n      = S_STALL;
          cnt_n     = gap;
          stalled_n = 1'b1;
        end
      end
      S_STALL: if (cnt == 4'd1) st_n = S_DATA;
      else cnt_n = cnt - 4'd1;
      default: st_n = st;
    endcase
    if (!run) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; hold_c <= 1'b0; stalled <= 1'b0; k <= '0;
      s_q <= '0; len_q <= '0; nowrap_q <= 1'b0; ilv_q <= 1'b0;
      early_q <= 1'b0; hold2_q <= 1'b0; lat_q <= 3'd2;
    end else begin
      st <= st_n; cnt <= cnt_n; hold_c <= hold_n; stalled <= stalled_n; k <= k_n;
      if (st == S_IDLE && run) begin
        s_q <= start_addr; len_q <= cfg_len; nowrap_q <= cfg_nowrap;
        ilv_q <= cfg_ilv; early_q <= cfg_wait_early; hold2_q <= cfg_hold2;
        lat_q <= lat_in;
      end
    end
  end

  wire inv_now = (st == S_LAT) || (st == S_STALL);
  wire inv_nxt = (st_n == S_LAT) || (st_n == S_STALL);
  wire in_bst  = (st == S_LAT) || (st == S_DATA) || (st == S_STALL);
  wire act     = early_q ? (in_bst && inv_nxt) : inv_now;

  assign dvalid = (st == S_DATA);
  assign dout   = dvalid ? {8'(arr_addr) ^ 8'hC3, 8'(arr_addr)} : 16'h0000;
  assign wait_o = act ? cfg_wait_hi : ~cfg_wait_hi;

endmodule

module burst_read_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en,
  input logic          burst_go,
  input logic          cfg_wait_early,
  input logic          cfg_wait_hi,
  input logic          cfg_hold2,
  input logic [AW-1:0] arr_addr,
  input logic          dvalid,
  input logic          wait_o
);

  a_r11_abort_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_go && chip_en) |=> !dvalid);

  a_r11_abort_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_go && chip_en) |=> (wait_o == !cfg_wait_hi));

  a_r2_no_instant_data: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(burst_go) && chip_en && !dvalid) |=> !dvalid);

  a_r9_wait_off_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && !cfg_wait_early) |-> (wait_o != cfg_wait_hi));

  a_r10_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dvalid) && cfg_hold2 && burst_go && chip_en) |=> (dvalid && $stable(arr_addr)));

endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_read_seq_tb.sv
`timescale 1ns/1ps
module burst_read_seq_tb;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, chip_en = 1'b0, burst_go = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0] cfg_len = '0;
  logic cfg_nowrap = 1'b0, cfg_ilv = 1'b0, cfg_wait_early = 1'b0;
  logic cfg_wait_hi = 1'b1, cfg_hold2 = 1'b0;
  logic [2:0] cfg_lat = 3'd2;
  logic [AW-1:0] arr_addr;
  logic [15:0] dout;
  logic dvalid, wait_o;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  burst_read_seq #(.AW(AW)) u_dut (.*);

  // {len, nowrap, ilv, early, pol, hold2, lat, start}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 8'h06},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 8'h2B},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4, 8'h35},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd5, 8'hF9},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 8'h0B},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 8'h0D},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 8'h0E},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 8'h0D},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 8'h0C},
    {2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd5, 8'h1F},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 8'h42},
    {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd7, 8'hFE},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 8'h3D},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 8'h00}
  };

  int ev [64];
  int ea [64];
  int ei [65];

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic build(input logic [17:0] v, output int t);
    int len, nw, ilv, hold, lat, s, n, c, off, d;
    bit lin, stl;
    len = int'(v[17:16]); nw = int'(v[15]); ilv = int'(v[14]);
    hold = v[11] ? 2 : 1; lat = int'(v[10:8]); s = int'(v[7:0]);
    if (lat < 2) lat = 2;
    n = 4 << len;
    lin = (nw == 1) || (len == 3);
    off = s % 4;
    d = (lat + off > 4) ? lat + off - 4 : 0;
    for (int i = 0; i < 64; i++) begin ev[i] = 0; ea[i] = 0; ei[i] = 0; end
    ei[64] = 0;
    c = 0; stl = 1'b0;
    for (int i = 0; i < lat; i++) begin ei[c] = 1; c++; end
    for (int k = 0; (len == 3 || k < n) && c < 64; k++) begin
      int a, base;
      base = s - (s % n);
      if (lin) a = (s + k) % 256;
      else if (ilv == 1) a = base + ((s % n) ^ k);
      else a = base + ((s % n) + k) % n;
      if (k > 0 && lin && !stl && off != 0 && ((s + k) % 16 == 0) && d > 0) begin
        stl = 1'b1;
        for (int j = 0; j < d && c < 64; j++) begin ei[c] = 1; c++; end
      end
      for (int h = 0; h < hold && c < 64; h++) begin ev[c] = 1; ea[c] = a; c++; end
    end
    t = c;
  endtask

  task automatic run_vec(input int idx);
    logic [17:0] v;
    int t, ncmp, w;
    bit pol, early;
    v = VEC[idx];
    build(v, t);
    pol = v[12]; early = v[13];
    @(negedge clk);
    burst_go = 1'b0;
    cfg_len = v[17:16]; cfg_nowrap = v[15]; cfg_ilv = v[14]; cfg_wait_early = v[13];
    cfg_wait_hi = v[12]; cfg_hold2 = v[11]; cfg_lat = v[10:8]; start_addr = v[7:0];
    @(negedge clk);
    check(wait_o == !pol, "R9 idle level", wait_o, !pol);
    burst_go = 1'b1;
    ncmp = (v[17:16] == 2'd3) ? 40 : t + 3;
    for (int c = 0; c < ncmp; c++) begin
      @(negedge clk);
      w = early ? ei[c + 1] : ei[c];
      // R2/R7/R8/R9/R13: empty-cycle schedule and wait level
      check(wait_o == (pol ? w[0] : !w[0]), "R8/R9 wait", wait_o, pol ? w : 1 - w);
      check(dvalid == ev[c][0], "R2/R7/R10/R13 valid", dvalid, ev[c]);
      if (ev[c] != 0) begin
        // R3/R4/R5/R6 address order, R12 data
        check(arr_addr == ea[c][7:0], "R3/R4/R5/R6 addr", arr_addr, ea[c]);
        check(dout == {ea[c][7:0] ^ 8'hC3, ea[c][7:0]}, "R12 data", dout,
              {ea[c][7:0] ^ 8'hC3, ea[c][7:0]});
      end else begin
        check(dout == 16'h0, "R12 idle data", dout, 0);
      end
    end
    burst_go = 1'b0;
    @(negedge clk);
    check(!dvalid && wait_o == !pol, "R11 release", {dvalid, wait_o}, {1'b0, !pol});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dvalid == 1'b0 && dout == 16'h0, "R1 reset valid/data", dout, 0);
    check(wait_o == 1'b0, "R1 reset wait", wait_o, 0);
    rst_n = 1'b1; chip_en = 1'b1;
    @(negedge clk);
    check(dvalid == 1'b0 && wait_o == 1'b0, "R1 idle after reset", {dvalid, wait_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R11: chip enable dropped during latency
    @(negedge clk);
    cfg_len = 2'd1; cfg_nowrap = 1'b0; cfg_ilv = 1'b0; cfg_wait_early = 1'b0;
    cfg_wait_hi = 1'b1; cfg_hold2 = 1'b0; cfg_lat = 3'd5; start_addr = 8'h10;
    burst_go = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(wait_o == 1'b1, "R2 wait in latency", wait_o, 1);
    chip_en = 1'b0;
    @(negedge clk);
    check(!dvalid && wait_o == 1'b0, "R11 chip_en release", {dvalid, wait_o}, 0);
    burst_go = 1'b0;
    @(negedge clk);
    chip_en = 1'b1;

    // R11: request dropped in the middle of data
    burst_go = 1'b1;
    repeat (7) @(negedge clk);
    check(dvalid == 1'b1 && arr_addr == 8'h11, "R11 data before abort", arr_addr, 8'h11);
    burst_go = 1'b0;
    @(negedge clk);
    check(!dvalid && wait_o == 1'b0, "R11 abort in data", {dvalid, wait_o}, 0);
    repeat (3) @(negedge clk);
    check(!dvalid, "R11 stays idle", dvalid, 0);

    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule